// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block chooses which of eleven interrupt sources an 8-bit microcontroller core services next. Each source brings a request flag, an enable bit and a one-bit level setting, all driven from software-visible register bits outside the block. The block keeps one in-service flag for each of the two levels. A higher-level request may nest on top of a lower-level routine. A request never nests inside a routine of its own level, and nothing interrupts a high-level routine.

The chosen request goes to the core as a valid/ready offer that carries a 16-bit vector address. Back-pressure rules: once `irq_valid_o` is high, the offer and its vector stay unchanged until the core raises `irq_ready_i`. An acknowledge is any cycle with valid and ready both high. In the cycle after an acknowledge, valid is low. The only way an offer is withdrawn without an acknowledge is for the master enable to drop. Arbitration runs in cycles where no offer is held, and its result is registered. The core pulses `reti_i` for one cycle when a service routine returns.

Source numbering follows the fixed polling order, and bit i of every per-source vector belongs to source i. The sources, from bit 0 to bit 10, are: supply monitor, watchdog, external 0, ADC ready, timer 0, external 1, timer 1, SPI/I2C, UART, timer 2, interval counter.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high, `irq_valid_o` is 0 after the next clock edge, and both in-service flags are cleared, so that after reset a request of either level can be offered.
- R2: A source whose bit in `irq_en_i` is 0 is never offered, even while its flag is set.
- R3: Bit i of `irq_hi_i` set to 1 puts source i on the high level. Set to 0, it puts source i on the low level.
- R4: While only the low level is in service, an enabled high-level request is offered.
- R5: No request is offered while its own level is in service, and no request is offered while the high level is in service.
- R6: When enabled requests of both levels are pending and both levels are allowed, a high-level source is offered.
- R7: Among allowed requests of the chosen level, the one with the lowest bit index wins.
- R8: The vector for bits 0 to 10 is, in order, 0043h, 005Bh, 0003h, 0033h, 000Bh, 0013h, 001Bh, 003Bh, 0023h, 002Bh, 0053h.
- R9: An offer appears one clock edge after its inputs are present. It is held with a stable vector while `irq_ready_i` is low. Valid is 0 in the cycle after an acknowledge.
- R10: An acknowledge sets the in-service flag of the offered level.
- R11: A `reti_i` pulse clears the high in-service flag if it is set, and otherwise clears the low flag.
- R12: With `master_en_i` at 0, `irq_valid_o` is 0 from the next edge on, and the in-service flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_flag_i | input | 11 | Request flag per source, in polling order |
| irq_en_i | input | 11 | Enable per source |
| irq_hi_i | input | 11 | Level per source (1 = high) |
| master_en_i | input | 1 | Master enable for all requests |
| reti_i | input | 1 | One-cycle pulse at the return from a service routine |
| irq_valid_o | output | 1 | Offer valid |
| irq_ready_i | input | 1 | Core accepts the offer |
| irq_vector_o | output | 16 | Vector address of the offered source |

## Verification
The assertions assume that the core raises `irq_ready_i` only as a single-cycle acceptance of a standing offer, and that `reti_i` is a single-cycle pulse issued only while some level is in service. They also assume that inputs settle well before each clock edge. The stimulus changes inputs only at falling edges. It acknowledges only offers it has just observed, and it pulses the return input only after it has built an in-service state through acknowledges of its own. Between patterns, the bench clears standing offers by dropping the master enable, never by changing flags underneath a held offer. The one exception is the deliberate test of hold stability.

// File: rtl/irqpc_pkg.sv
package irqpc_pkg;
  localparam int NSRC_DEF  = 11;
  localparam int VEC_W     = 16;
  localparam int SLOT_W    = 4;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
  localparam int SLOT_SHIFT = 3;

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  // Slot in the vector table for each polling position.
  function automatic logic [SLOT_W-1:0] slot_of(input int unsigned pos);
    logic [SLOT_W-1:0] s;
    case (pos)
      0:       s = 4'd8;
      1:       s = 4'd11;
      2:       s = 4'd0;
      3:       s = 4'd6;
      4:       s = 4'd1;
      5:       s = 4'd2;
      6:       s = 4'd3;
      7:       s = 4'd7;
      8:       s = 4'd4;
      9:       s = 4'd5;
      10:      s = 4'd10;
      default: s = 4'd0;
    endcase
    return s;
  endfunction

  function automatic logic [VEC_W-1:0] vector_of(input int unsigned pos);
    logic [VEC_W-1:0] off;
    off = VEC_W'(slot_of(pos)) << SLOT_SHIFT;
    return VEC_BASE + off;
  endfunction
endpackage

// File: rtl/irqpc_first_pick.sv
module irqpc_first_pick #(
  parameter int N = 11,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] cand,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/irqpc_arbiter.sv
module irqpc_arbiter
  import irqpc_pkg::*;
#(
  parameter int N = NSRC_DEF,
  localparam int W = (N > 1) ? $clog2(N) : 1,
  localparam int NLVL = 2
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  input  logic [N-1:0] hi,
  input  logic         master_en,
  input  logic         hi_act,
  input  logic         lo_act,
  output logic         cand_valid,
  output logic [W-1:0] cand_idx,
  output lvl_e         cand_lvl
);
  logic [N-1:0] live;
  logic [N-1:0] lvl_cand [NLVL];
  logic [NLVL-1:0] lvl_hit;
  logic [W-1:0] lvl_idx [NLVL];
  logic [NLVL-1:0] lvl_allow;

  assign live = flag & en & {N{master_en}};
  assign lvl_cand[LVL_HI] = live & hi;
  assign lvl_cand[LVL_LO] = live & ~hi;
  assign lvl_allow[LVL_HI] = ~hi_act;
  assign lvl_allow[LVL_LO] = ~hi_act & ~lo_act;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    irqpc_first_pick #(.N(N)) u_pick (
      .cand (lvl_cand[g]),
      .hit  (lvl_hit[g]),
      .idx  (lvl_idx[g])
    );
  end

  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = '0;
    cand_lvl   = LVL_LO;
    if (lvl_allow[LVL_HI] && lvl_hit[LVL_HI]) begin
      cand_valid = 1'b1;
      cand_idx   = lvl_idx[LVL_HI];
      cand_lvl   = LVL_HI;
    end else if (lvl_allow[LVL_LO] && lvl_hit[LVL_LO]) begin
      cand_valid = 1'b1;
      cand_idx   = lvl_idx[LVL_LO];
      cand_lvl   = LVL_LO;
    end
  end
endmodule

// File: rtl/irqpc_inservice.sv
module irqpc_inservice
  import irqpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack,
  input  lvl_e ack_lvl,
  input  logic reti,
  output logic hi_act,
  output logic lo_act
);
  logic hi_nxt, lo_nxt;

  always_comb begin
    hi_nxt = hi_act;
    lo_nxt = lo_act;
    if (reti) begin
      if (hi_act) hi_nxt = 1'b0;
      else        lo_nxt = 1'b0;
    end
    if (ack) begin
      if (ack_lvl == LVL_HI) hi_nxt = 1'b1;
      else                   lo_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_act <= 1'b0;
      lo_act <= 1'b0;
    end else begin
      hi_act <= hi_nxt;
      lo_act <= lo_nxt;
    end
  end
endmodule

// File: rtl/irqpc_offer_reg.sv
module irqpc_offer_reg
  import irqpc_pkg::*;
#(
  parameter int N = NSRC_DEF,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_en,
  input  logic             cand_valid,
  input  logic [W-1:0]     cand_idx,
  input  lvl_e             cand_lvl,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vector,
  output lvl_e             lvl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      vector <= '0;
      lvl    <= LVL_LO;
    end else if (valid) begin
      if (ready || !master_en) valid <= 1'b0;
    end else if (!master_en) begin
      valid <= 1'b0;
    end else begin
      valid  <= cand_valid;
      vector <= vector_of(32'(cand_idx));
      lvl    <= cand_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqpc_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_flag_i,
  input  logic [NSRC-1:0]   irq_en_i,
  input  logic [NSRC-1:0]   irq_hi_i,
  input  logic              master_en_i,
  input  logic              reti_i,
  output logic              irq_valid_o,
  input  logic              irq_ready_i,
  output logic [VEC_W-1:0]  irq_vector_o
);
  logic          hi_act, lo_act;
  logic          cand_valid;
  logic [IW-1:0] cand_idx;
  lvl_e          cand_lvl;
  lvl_e          offer_lvl;
  logic          ack;

  assign ack = irq_valid_o & irq_ready_i;

  irqpc_arbiter #(.N(NSRC)) u_arb (
    .flag       (irq_flag_i),
    .en         (irq_en_i),
    .hi         (irq_hi_i),
    .master_en  (master_en_i),
    .hi_act     (hi_act),
    .lo_act     (lo_act),
    .cand_valid (cand_valid),
    .cand_idx   (cand_idx),
    .cand_lvl   (cand_lvl)
  );

  irqpc_offer_reg #(.N(NSRC)) u_offer (
    .clk        (clk),
    .rst        (rst),
    .master_en  (master_en_i),
    .cand_valid (cand_valid),
    .cand_idx   (cand_idx),
    .cand_lvl   (cand_lvl),
    .ready      (irq_ready_i),
    .valid      (irq_valid_o),
    .vector     (irq_vector_o),
    .lvl        (offer_lvl)
  );

  irqpc_inservice u_isr (
    .clk     (clk),
    .rst     (rst),
    .ack     (ack),
    .ack_lvl (offer_lvl),
    .reti    (reti_i),
    .hi_act  (hi_act),
    .lo_act  (lo_act)
  );
endmodule

// File: rtl/irqpc_checker.sv
module irqpc_checker
  import irqpc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic             ready,
  input logic [VEC_W-1:0] vec,
  input logic             master_en,
  input logic             reti,
  input logic             hi_flag,
  input logic             lo_flag,
  input lvl_e             lvl
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !valid);

  // R5
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (!hi_flag && (lvl == LVL_HI || !lo_flag)));

  // R8
  vec_align_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (vec[2:0] == 3'b011 && vec <= 16'h005B));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && master_en) |=> (valid && $stable(vec) && $stable(lvl)));

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ready) |=> !valid);

  // R10
  ack_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && lvl == LVL_HI) |=> hi_flag);

  // R11
  reti_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && hi_flag) |=> !hi_flag);

  // R11
  reti_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !hi_flag && lo_flag) |=> !lo_flag);

  // R12
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !valid);

  // R12
  flags_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_en && !reti) |=> ($stable(hi_flag) && $stable(lo_flag)));
endmodule

bind irq_prio_ctrl irqpc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid     (irq_valid_o),
  .ready     (irq_ready_i),
  .vec       (irq_vector_o),
  .master_en (master_en_i),
  .reti      (reti_i),
  .hi_flag   (hi_act),
  .lo_flag   (lo_act),
  .lvl       (offer_lvl)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int N = 11;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] f = '0, e = '0, h = '0;
  logic me = 1'b0, reti = 1'b0, ready = 1'b0;
  logic valid;
  logic [15:0] vec;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit hs = 1'b0, ls = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst(rst), .irq_flag_i(f), .irq_en_i(e), .irq_hi_i(h),
    .master_en_i(me), .reti_i(reti), .irq_valid_o(valid),
    .irq_ready_i(ready), .irq_vector_o(vec)
  );

  // R8 table
  function automatic logic [15:0] vec_exp(input int s);
    case (s)
      0: return 16'h0043;  1: return 16'h005B;  2: return 16'h0003;
      3: return 16'h0033;  4: return 16'h000B;  5: return 16'h0013;
      6: return 16'h001B;  7: return 16'h003B;  8: return 16'h0023;
      9: return 16'h002B;  10: return 16'h0053;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int pick_exp(input logic [N-1:0] ff, input logic [N-1:0] ee,
                                  input logic [N-1:0] hh, input bit m);
    if (!m) return -1;
    if (!hs)
      for (int s = 0; s < N; s++) if (ff[s] && ee[s] && hh[s]) return s;
    if (!hs && !ls)
      for (int s = 0; s < N; s++) if (ff[s] && ee[s] && !hh[s]) return s;
    return -1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int exp_s);
    logic [16:0] act, expv;
    checks++;
    act  = valid ? {1'b1, vec} : 17'd0;
    expv = (exp_s >= 0) ? {1'b1, vec_exp(exp_s)} : 17'd0;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got valid/vec %h, expected %h", tag, act, expv);
    end
  endtask

  task automatic offer(input string tag, input logic [N-1:0] ff,
                       input logic [N-1:0] ee, input logic [N-1:0] hh);
    me = 1'b0; step();
    f = ff; e = ee; h = hh; me = 1'b1; step();
    chk(tag, pick_exp(ff, ee, hh, 1'b1));
  endtask

  task automatic ack_it(input bit lvl);
    ready = 1'b1; step(); ready = 1'b0;
    if (lvl) hs = 1'b1; else ls = 1'b1;
  endtask

  task automatic reti_it();
    reti = 1'b1; step(); reti = 1'b0;
    if (hs) hs = 1'b0; else ls = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; f = ALL; e = ALL; h = '0; me = 1'b1; step(); step();
    chk("R1 valid low in reset", -1);
    rst = 1'b0; hs = 1'b0; ls = 1'b0;
    me = 1'b0; step();
  endtask

  task automatic set_state(input bit want_hi, input bit want_lo);
    do_reset();
    if (want_lo) begin offer("R1 lo after reset", 11'(1) << 2, ALL, '0); ack_it(1'b0); end
    if (want_hi) begin offer("R1 hi after reset", 11'(1) << 4, ALL, ALL); ack_it(1'b1); end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    do_reset();

    // R2 R3 R8: each source alone, both levels, enabled and disabled
    for (int s = 0; s < N; s++)
      for (int p = 0; p < 2; p++)
        for (int en_on = 0; en_on < 2; en_on++)
          offer("R2 R3 R8 single source", 11'(1) << s,
                en_on ? ALL : ~(11'(1) << s), p ? ALL : '0);

    // R7: same-level pairs
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        for (int p = 0; p < 2; p++)
          offer("R7 polling order", (11'(1) << i) | (11'(1) << j), ALL, p ? ALL : '0);

    // R6: mixed-level pairs
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j)
          offer("R6 high first", (11'(1) << i) | (11'(1) << j), ALL, 11'(1) << i);

    // R4 R5 R2: pseudo-random patterns under every in-service state
    for (int st = 0; st < 4; st++) begin
      set_state(st[1], st[0]);
      for (int k = 0; k < 60; k++) begin
        logic [N-1:0] rf, re, rh;
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; rf = seed[10:0];
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; re = seed[10:0];
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; rh = seed[10:0];
        offer("R4 R5 R2 pattern vs in-service", rf, re, rh);
      end
    end

    // R9: hold, stability and acknowledge
    set_state(1'b0, 1'b0);
    me = 1'b0; step();
    f = 11'(1) << 5; e = ALL; h = '0; me = 1'b1; step();
    chk("R9 offer after one edge", 5);
    f = 11'(1) << 0; step();
    chk("R9 held against better request", 5);
    f = '0; step();
    chk("R9 held after flag drop", 5);
    f = 11'(1) << 5;
    ack_it(1'b0);
    chk("R9 valid low after acknowledge", -1);

    // R10 R5 R4
    offer("R5 R10 low blocked by low in service", 11'(1) << 0, ALL, '0);
    offer("R4 high nests over low", 11'(1) << 9, ALL, ALL);
    ack_it(1'b1);
    offer("R5 high blocked by high in service", 11'(1) << 0, ALL, ALL);
    offer("R5 low blocked by high in service", 11'(1) << 1, ALL, '0);

    // R12: gating keeps flags
    f = ALL; e = ALL; h = '0; me = 1'b0; step(); step();
    chk("R12 master enable off", -1);
    for (int k = 0; k < 4; k++) step();
    offer("R12 flags kept while gated", 11'(1) << 3, ALL, ALL);

    // R11: return ordering
    reti_it();
    offer("R11 high cleared first, high grantable", 11'(1) << 7, ALL, ALL);
    offer("R11 low still in service", 11'(1) << 7, ALL, '0);
    reti_it();
    offer("R11 low cleared on second return", 11'(1) << 8, ALL, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule